// File: doc/BRIEF.md
# Multiplexed Signed Decimal Display Scanner

This block turns a 16-bit binary value into the drive signals for a six-position segmented numeric display, lighting one position at a time. A position counter advances on each pulse of a scan tick and walks through five decimal digit positions and one sign position. For the position currently selected, the block outputs a 16-bit segment pattern and a one-hot enable for that position. When the positions are refreshed fast enough, the whole number appears at once.

A mode input picks how the value is read. In unsigned mode the value is read as 0 to 65535. In signed mode it is read as two's complement (-32768 to 32767): the digit positions show the magnitude, and the sign position lights a minus pattern for negative values. The decimal digits are computed in logic rather than read from a stored table. An active-low enable blanks the display while the scan goes on.

Top module: `dec_scan_display`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, the scan position is set to 0. Right after reset, with the display enabled, `pos_en` is 6'b000001.
- R2: A rising edge with `scan_tick` high moves the scan position up by one. A rising edge with `scan_tick` low leaves it unchanged.
- R3: A tick while the position is 5 returns the position to 0. The position never takes the values 6 or 7.
- R4: While the display is enabled, exactly one bit of `pos_en` is high, and that bit is `pos_en[k]` for scan position k. Scan codes 6 and 7 drive no enable and a zero pattern.
- R5: Positions 0 to 4 show the ones, tens, hundreds, thousands and ten-thousands digits. Digits 0 to 9 use the patterns 0x3F, 0x06, 0xDB, 0x8F, 0xE6, 0xED, 0xFD, 0x07, 0xFF, 0xEF in that order, in the low byte of `seg`. The upper byte of `seg` is zero.
- R6: With `signed_mode` = 0, the value is read as unsigned and position 5 always shows 0x0000.
- R7: With `signed_mode` = 1, the value is read as two's complement. Positions 0 to 4 show the digits of its absolute value, and -32768 shows 32768.
- R8: With `signed_mode` = 1, position 5 shows 0x00C0 when bit 15 of the value is 1, and 0x0000 otherwise.
- R9: While `disp_en_n` is high, `pos_en` is all zero and `seg` is all zero, and the scan position keeps advancing on ticks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| scan_tick | input | 1 | Advances the scan position by one |
| disp_en_n | input | 1 | Display enable, active low |
| signed_mode | input | 1 | 1: two's complement, 0: unsigned |
| value | input | 16 | Number to display |
| seg | output | 16 | Segment pattern for the active position |
| pos_en | output | 6 | One-hot position enable |

## Verification
The bench goes after the extreme values: 0, 65535, 32767, -1 and -32768. A design that negated the value without handling the wrap at -32768, or that forgot the mode, would show wrong digits or a stray sign there. It also checks the wrap from position 5 back to 0. A counter that fell through to codes 6 and 7 would show two dark slots, with no enable raised. Finally, the bench ticks while the display is disabled and checks where the scan stands once the display is enabled again. A blanking that also froze the counter would then show the wrong position.

// File: rtl/disp_pkg.sv
// Package for the display scanner: default sizes, the digit pattern table
// and the sign pattern. Assumes a 16-bit segment word, with digit patterns
// held in the low byte.
package disp_pkg;
    localparam int SEG_W = 16;

    localparam logic [SEG_W-1:0] SIGN_NEG_PAT = 16'h00C0;

    // Segment pattern for one decimal digit; codes above 9 give blank
    function automatic logic [SEG_W-1:0] digit_pattern(input logic [3:0] d);
        logic [SEG_W-1:0] p;
        case (d)
            4'd0:    p = 16'h003F;
            4'd1:    p = 16'h0006;
            4'd2:    p = 16'h00DB;
            4'd3:    p = 16'h008F;
            4'd4:    p = 16'h00E6;
            4'd5:    p = 16'h00ED;
            4'd6:    p = 16'h00FD;
            4'd7:    p = 16'h0007;
            4'd8:    p = 16'h00FF;
            4'd9:    p = 16'h00EF;
            default: p = '0;
        endcase
        return p;
    endfunction
endpackage

// File: rtl/scan_counter.sv
// Scan counter: steps through positions 0..NUM_POS-1 on each tick and wraps
// back to 0. Assumes a synchronous active-low reset. Any code at or above
// NUM_POS also returns to 0 on the next tick.
module scan_counter #(
    parameter int NUM_POS = 6,
    parameter int SEL_W   = $clog2(NUM_POS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    output logic [SEL_W-1:0] pos
);
    localparam logic [SEL_W-1:0] LAST = SEL_W'(NUM_POS - 1);

    // Advance the position on a tick, wrapping after the last used code
    always_ff @(posedge clk) begin
        if (!rst_n)
            pos <= '0;
        else if (tick)
            pos <= (pos >= LAST) ? '0 : pos + SEL_W'(1);
    end
endmodule

// File: rtl/pos_decoder.sv
// Position decoder: one-hot enable for the selected position, all low when
// blanked. Codes at or above NUM_POS enable nothing.
module pos_decoder #(
    parameter int NUM_POS = 6,
    parameter int SEL_W   = $clog2(NUM_POS)
) (
    input  logic [SEL_W-1:0]   pos,
    input  logic               blank,
    output logic [NUM_POS-1:0] en
);
    for (genvar k = 0; k < NUM_POS; k++) begin : g_en
        // Each enable is high only for its own code
        assign en[k] = !blank && (pos == SEL_W'(k));
    end
endmodule

// File: rtl/digit_path.sv
// Digit path: takes the magnitude (the value itself, or its negation for a
// negative signed value), converts it to decimal by shift-and-add-3 and
// gives one segment pattern per digit position, plus the sign pattern.
// Assumes NUM_DIG digits are enough for the largest value 2**VAL_W - 1.
module digit_path
    import disp_pkg::*;
#(
    parameter int VAL_W   = 16,
    parameter int NUM_DIG = 5
) (
    input  logic [VAL_W-1:0]           value,
    input  logic                       signed_mode,
    output logic [NUM_DIG-1:0][SEG_W-1:0] dig_pat,
    output logic [SEG_W-1:0]           sign_pat
);
    localparam int BCD_W = 4 * NUM_DIG;

    logic             negative;
    logic [VAL_W-1:0] mag;
    logic [BCD_W-1:0] bcd;

    // Sign and magnitude: negation wraps 0x8000 onto itself, giving 32768
    always_comb begin
        negative = signed_mode && value[VAL_W-1];
        mag      = negative ? (~value + VAL_W'(1)) : value;
    end

    // Binary to packed decimal by shift-and-add-3
    always_comb begin
        bcd = '0;
        for (int i = VAL_W - 1; i >= 0; i--) begin
            for (int d = 0; d < NUM_DIG; d++) begin
                if (bcd[4*d +: 4] >= 4'd5)
                    bcd[4*d +: 4] = bcd[4*d +: 4] + 4'd3;
            end
            bcd = {bcd[BCD_W-2:0], mag[i]};
        end
    end

    for (genvar d = 0; d < NUM_DIG; d++) begin : g_pat
        // Pattern for decimal place d
        assign dig_pat[d] = digit_pattern(bcd[4*d +: 4]);
    end

    // Minus sign only for a negative value in signed mode
    assign sign_pat = negative ? SIGN_NEG_PAT : '0;
endmodule

// File: rtl/dec_scan_display.sv
// Top of the display scanner: scan counter, digit path, position decoder
// and the pattern select for the active position. Positions 0..NUM_DIG-1
// are decimal places, position NUM_DIG is the sign. Assumes the scan tick
// is a single-cycle pulse in the clk domain.
module dec_scan_display
    import disp_pkg::*;
#(
    parameter int VAL_W   = 16,
    parameter int NUM_DIG = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             scan_tick,
    input  logic             disp_en_n,
    input  logic             signed_mode,
    input  logic [VAL_W-1:0] value,
    output logic [SEG_W-1:0] seg,
    output logic [NUM_DIG:0] pos_en
);
    localparam int NUM_POS = NUM_DIG + 1;
    localparam int SEL_W   = $clog2(NUM_POS);

    logic [SEL_W-1:0]             scan_pos;
    logic [NUM_DIG-1:0][SEG_W-1:0] dig_pat;
    logic [SEG_W-1:0]             sign_pat;

    scan_counter #(.NUM_POS(NUM_POS), .SEL_W(SEL_W)) u_cnt (
        .clk  (clk),
        .rst_n(rst_n),
        .tick (scan_tick),
        .pos  (scan_pos)
    );

    digit_path #(.VAL_W(VAL_W), .NUM_DIG(NUM_DIG)) u_dig (
        .value      (value),
        .signed_mode(signed_mode),
        .dig_pat    (dig_pat),
        .sign_pat   (sign_pat)
    );

    pos_decoder #(.NUM_POS(NUM_POS), .SEL_W(SEL_W)) u_dec (
        .pos  (scan_pos),
        .blank(disp_en_n),
        .en   (pos_en)
    );

    // Pick the pattern of the active position; unused codes and blank give zero
    always_comb begin
        seg = '0;
        if (!disp_en_n) begin
            for (int k = 0; k < NUM_DIG; k++) begin
                if (scan_pos == SEL_W'(k))
                    seg = dig_pat[k];
            end
            if (scan_pos == SEL_W'(NUM_DIG))
                seg = sign_pat;
        end
    end
endmodule

// File: rtl/dec_scan_display_chk.sv
// Checker for the display scanner, bound to every instance of the top.
module dec_scan_display_chk #(
    parameter int NUM_DIG = 5,
    parameter int SEL_W   = 3,
    parameter int SEG_W   = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             scan_tick,
    input logic             disp_en_n,
    input logic [SEL_W-1:0] scan_pos,
    input logic [SEG_W-1:0] seg,
    input logic [NUM_DIG:0] pos_en
);
    localparam logic [SEL_W-1:0] LAST = SEL_W'(NUM_DIG);

    AST_POS_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        scan_pos <= LAST); // R3
    AST_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        scan_tick && scan_pos == LAST |=> scan_pos == '0); // R3
    AST_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        scan_tick && scan_pos < LAST |=> scan_pos == $past(scan_pos) + SEL_W'(1)); // R2
    AST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !scan_tick |=> $stable(scan_pos)); // R2
    AST_ONE_EN: assert property (@(posedge clk) disable iff (!rst_n)
        !disp_en_n |-> $countones(pos_en) == 1); // R4
    AST_EN_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        !disp_en_n |-> pos_en[scan_pos]); // R4
    AST_BLANK: assert property (@(posedge clk) disable iff (!rst_n)
        disp_en_n |-> (pos_en == '0 && seg == '0)); // R9
    AST_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        seg[SEG_W-1:8] == '0); // R5
endmodule

bind dec_scan_display dec_scan_display_chk #(
    .NUM_DIG(NUM_DIG), .SEL_W(SEL_W), .SEG_W(disp_pkg::SEG_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .scan_tick(scan_tick),
    .disp_en_n(disp_en_n),
    .scan_pos (scan_pos),
    .seg      (seg),
    .pos_en   (pos_en)
);

// File: tb/tb_dec_scan_display.sv
module tb_dec_scan_display;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        scan_tick = 1'b0;
    logic        disp_en_n = 1'b0;
    logic        signed_mode = 1'b0;
    logic [15:0] value = '0;
    logic [15:0] seg;
    logic [5:0]  pos_en;

    int total = 0;
    int bad = 0;
    int mpos = 0;
    int seed = 1234;

    always #4 clk = ~clk;

    dec_scan_display dut (
        .clk(clk), .rst_n(rst_n), .scan_tick(scan_tick), .disp_en_n(disp_en_n),
        .signed_mode(signed_mode), .value(value), .seg(seg), .pos_en(pos_en)
    );

    function automatic logic [15:0] pat_of(input int d);
        case (d)
            0: return 16'h3F; 1: return 16'h06; 2: return 16'hDB; 3: return 16'h8F;
            4: return 16'hE6; 5: return 16'hED; 6: return 16'hFD; 7: return 16'h07;
            8: return 16'hFF; default: return 16'hEF;
        endcase
    endfunction

    function automatic logic [15:0] exp_seg(input int p, input logic sm, input logic [15:0] v, input logic en_n);
        int mag;
        int dv;
        if (en_n) return 16'h0;
        if (p == 5) return (sm && v[15]) ? 16'h00C0 : 16'h0000;
        mag = (sm && v[15]) ? 65536 - int'(v) : int'(v);
        dv = 1;
        for (int i = 0; i < p; i++) dv = dv * 10;
        return pat_of((mag / dv) % 10);
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s pos=%0d val=%h mode=%0d act=%h exp=%h", req, mpos, value, signed_mode, act, exp);
        end
    endtask

    // Drive one cycle: set inputs at negedge, check outputs, then clock
    task automatic cyc(input logic t, input logic en_n, input logic sm, input logic [15:0] v, input string req);
        @(negedge clk);
        scan_tick = t; disp_en_n = en_n; signed_mode = sm; value = v;
        #1;
        chk(req, {16'h0, seg}, {16'h0, exp_seg(mpos, sm, v, en_n)});
        chk(req, {26'h0, pos_en}, en_n ? 32'h0 : (32'h1 << mpos));
        @(posedge clk);
        if (t) mpos = (mpos == 5) ? 0 : mpos + 1;
    endtask

    // Sweep all six positions for one value
    task automatic sweep(input logic sm, input logic [15:0] v, input string req);
        for (int k = 0; k < 6; k++) cyc(1'b1, 1'b0, sm, v, req);
    endtask

    initial begin
        #1_000_000;
        bad++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        void'($urandom(seed));
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        mpos = 0;
        // R1: reset state
        @(negedge clk); #1;
        chk("R1", {26'h0, pos_en}, 32'h1);
        chk("R1", {16'h0, seg}, {16'h0, 16'h3F});
        // R2: no tick holds position
        cyc(1'b0, 1'b0, 1'b0, 16'd7, "R2");
        cyc(1'b0, 1'b0, 1'b0, 16'd7, "R2");
        // R5/R6: unsigned extremes and digit patterns
        sweep(1'b0, 16'd0, "R5");
        sweep(1'b0, 16'd65535, "R6");
        sweep(1'b0, 16'd12345, "R5");
        sweep(1'b0, 16'd67890 - 16'd0, "R5");
        sweep(1'b0, 16'hFFF0, "R6");
        // R7/R8: signed corners
        sweep(1'b1, 16'h8000, "R7");
        sweep(1'b1, 16'hFFFF, "R8");
        sweep(1'b1, 16'h7FFF, "R7");
        sweep(1'b1, 16'd0, "R8");
        sweep(1'b1, 16'hD8F1, "R7");
        // R3: repeated wraps
        for (int k = 0; k < 14; k++) cyc(1'b1, 1'b0, 1'b0, 16'd40960, "R3");
        // R9: blanked while ticking, then position is where the count says
        for (int k = 0; k < 4; k++) cyc(1'b1, 1'b1, 1'b1, 16'h8001, "R9");
        sweep(1'b1, 16'h8001, "R9");
        // R4: random mix
        for (int k = 0; k < 3000; k++) begin
            logic [15:0] rv;
            rv = 16'($urandom);
            cyc(1'($urandom), ($urandom % 8) == 0, 1'($urandom), rv, "R4");
        end
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule